// File: doc/BRIEF.md
# NMI Source Bitmask Accumulator

This block gathers the causes of non-maskable interrupts for one processor core. Each NMI message that arrives carries an 8-bit source vector. The block turns that vector into one bit of a pending source mask. A rising edge on the core's local external NMI pin is treated the same way, using a vector held in a small configuration register. Bits pile up across any number of arrivals until the core takes the NMI. While any bit is set, a pending flag is raised.

When the core pulses its accept input, it reads the accumulated mask from the mask output in that same cycle, and the register is cleared. Any source that arrives in the accept cycle lands in the freshly cleared mask, so it is not lost. A vector of zero means the sender named no source. Such a vector, and any vector at or above the mask width, sets bit 0. Handler software reads bit 0 as "poll everything". A pin vector of 2 makes bit 2 a second, narrower catch-all for events that have no vector of their own.

Top module: `nmi_src_accum`

## Requirements
- R1: A message with a vector v below the mask width (16 by default) sets bit v of src_mask at the clock edge that samples msg_valid; no other bit is set by it.
- R2: A message with vector 0 sets bit 0.
- R3: A message whose vector is at or above the mask width sets bit 0 and no other bit; this holds for every vector value 16 to 255 at the default width.
- R4: Without core_accept, a set mask bit stays set; successive arrivals OR into the mask.
- R5: In the cycle core_accept is high, src_mask shows the full accumulated mask. After that edge the mask holds only the arrivals sampled in the accept cycle.
- R6: nmi_pending is high exactly when src_mask is non-zero.
- R7: ext_nmi_pin passes through a two-flop synchronizer, and only a 0-to-1 transition registers an arrival. The mask bit appears after the third rising clock edge following the pin change. A pin held high raises no further arrivals.
- R8: After reset the pin vector is 0, so a pin edge sets bit 0.
- R9: A write with vec_cfg_we high loads vec_cfg_data as the pin vector at that edge. Later pin edges set that bit, or bit 0 when the value is at or above the mask width.
- R10: A message and a pin arrival sampled in the same cycle both set their bits.
- R11: During and right after reset, src_mask is 0 and nmi_pending is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msg_valid | input | 1 | An NMI message arrives this cycle |
| msg_vec | input | 8 | Source vector carried by the message |
| ext_nmi_pin | input | 1 | Asynchronous local external NMI pin |
| vec_cfg_we | input | 1 | Write strobe for the pin vector register |
| vec_cfg_data | input | 8 | New pin vector value |
| core_accept | input | 1 | One-cycle pulse: core takes the NMI and the mask |
| nmi_pending | output | 1 | Some source bit is pending |
| src_mask | output | MASK_W | Accumulated source mask |

## Verification
A corrupted mask register would show on src_mask and nmi_pending one edge after the arrival that should have set a bit. It would also show at the accept cycle, where the bits read out are compared against a model that ORs the vectors in the bench. A wrong fold of an out-of-range vector would show as a stray high bit, or as a missing bit 0, on the very next cycle. The bench sweeps all 256 message vectors and a range of pin vectors. A fault in the synchronizer or edge detector would move the pin's bit away from the third edge, or would re-raise it while the pin stays high, and the bench checks both one cycle at a time.

// File: rtl/nmi_src_pkg.sv
package nmi_src_pkg;
    localparam int unsigned VEC_W      = 8;
    localparam int unsigned MAX_MASK_W = 64;

    typedef logic [VEC_W-1:0] src_vec_t;

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } pin_sync_t;
endpackage

// File: rtl/nmi_vec_decode.sv
module nmi_vec_decode
    import nmi_src_pkg::*;
#(
    parameter int unsigned MASK_W = 16
) (
    input  logic              valid,
    input  src_vec_t          vec,
    output logic [MASK_W-1:0] hit
);
    logic in_range;
    assign in_range = (32'(vec) < MASK_W);

    // bit 0 collects "no source" and every vector beyond the mask
    assign hit[0] = valid && ((vec == '0) || !in_range);

    for (genvar i = 1; i < MASK_W; i++) begin : g_bit
        assign hit[i] = valid && (vec == VEC_W'(i));
    end
endmodule

// File: rtl/nmi_pin_sync.sv
module nmi_pin_sync
    import nmi_src_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic rise
);
    pin_sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.s1   = pin_async;
        sync_d.s2   = sync_q.s1;
        sync_d.prev = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rise = sync_q.s2 & ~sync_q.prev;
endmodule

// File: rtl/nmi_mask_reg.sv
module nmi_mask_reg #(
    parameter int unsigned MASK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MASK_W-1:0] set_bits,
    input  logic              accept,
    output logic [MASK_W-1:0] mask
);
    typedef struct packed {
        logic [MASK_W-1:0] bits;
    } mask_st_t;

    mask_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bits = (accept ? '0 : st_q.bits) | set_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask = st_q.bits;
endmodule

// File: rtl/nmi_src_accum.sv
module nmi_src_accum
    import nmi_src_pkg::*;
#(
    parameter int unsigned MASK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_valid,
    input  logic [7:0]        msg_vec,
    input  logic              ext_nmi_pin,
    input  logic              vec_cfg_we,
    input  logic [7:0]        vec_cfg_data,
    input  logic              core_accept,
    output logic              nmi_pending,
    output logic [MASK_W-1:0] src_mask
);
    if (MASK_W < 2 || MASK_W > MAX_MASK_W) begin : g_bad_width
        initial $error("MASK_W out of supported range");
    end

    typedef struct packed {
        src_vec_t pin_vec;
    } cfg_st_t;

    cfg_st_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (vec_cfg_we) cfg_d.pin_vec = vec_cfg_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    logic              pin_rise;
    logic [MASK_W-1:0] msg_hit;
    logic [MASK_W-1:0] pin_hit;
    logic [MASK_W-1:0] set_bits;

    nmi_pin_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (ext_nmi_pin),
        .rise      (pin_rise)
    );

    nmi_vec_decode #(.MASK_W(MASK_W)) u_dec_msg (
        .valid (msg_valid),
        .vec   (msg_vec),
        .hit   (msg_hit)
    );

    nmi_vec_decode #(.MASK_W(MASK_W)) u_dec_pin (
        .valid (pin_rise),
        .vec   (cfg_q.pin_vec),
        .hit   (pin_hit)
    );

    assign set_bits = msg_hit | pin_hit;

    nmi_mask_reg #(.MASK_W(MASK_W)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (set_bits),
        .accept   (core_accept),
        .mask     (src_mask)
    );

    assign nmi_pending = |src_mask;
endmodule

// File: rtl/nmi_src_accum_chk.sv
module nmi_src_accum_chk #(
    parameter int unsigned MASK_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              msg_valid,
    input logic [7:0]        msg_vec,
    input logic              core_accept,
    input logic              pin_rise,
    input logic              nmi_pending,
    input logic [MASK_W-1:0] src_mask
);
    AST_MSG_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && (32'(msg_vec) < MASK_W)) |=> ((src_mask >> $past(msg_vec)) & 1) != 0); // R1

    AST_FOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && (32'(msg_vec) >= MASK_W)) |=> src_mask[0]); // R3

    AST_BITS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !core_accept |=> ((src_mask & $past(src_mask)) == $past(src_mask))); // R4

    AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (core_accept && !msg_valid && !pin_rise) |=> (src_mask == '0)); // R5

    AST_PEND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_pending) |-> $past(msg_valid || pin_rise)); // R6
endmodule

bind nmi_src_accum nmi_src_accum_chk #(.MASK_W(MASK_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .msg_valid   (msg_valid),
    .msg_vec     (msg_vec),
    .core_accept (core_accept),
    .pin_rise    (pin_rise),
    .nmi_pending (nmi_pending),
    .src_mask    (src_mask)
);

// File: tb/nmi_src_accum_tb_top.sv
module nmi_src_accum_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          msg_valid = 1'b0;
    logic [7:0]    msg_vec = '0;
    logic          ext_nmi_pin = 1'b0;
    logic          vec_cfg_we = 1'b0;
    logic [7:0]    vec_cfg_data = '0;
    logic          core_accept = 1'b0;
    logic          nmi_pending;
    logic [MW-1:0] src_mask;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nmi_src_accum #(.MASK_W(MW)) dut_i (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_vec(msg_vec),
        .ext_nmi_pin(ext_nmi_pin), .vec_cfg_we(vec_cfg_we), .vec_cfg_data(vec_cfg_data),
        .core_accept(core_accept), .nmi_pending(nmi_pending), .src_mask(src_mask)
    );

    function automatic logic [MW-1:0] exp_bit(input int v);
        return (v == 0 || v >= MW) ? MW'(1) : (MW'(1) << v);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic chk_mask(input string tag, input logic [MW-1:0] expv);
        check(src_mask == expv, tag, 64'(src_mask), 64'(expv));
        check(nmi_pending == (expv != '0), {tag, " R6 pending"}, 64'(nmi_pending), 64'(expv != '0));
    endtask

    task automatic send_msg(input int v);
        @(negedge clk); msg_valid = 1'b1; msg_vec = 8'(v);
        @(negedge clk); msg_valid = 1'b0;
    endtask

    task automatic do_accept(input string tag, input logic [MW-1:0] expv);
        @(negedge clk); core_accept = 1'b1;
        chk_mask(tag, expv);
        @(negedge clk); core_accept = 1'b0;
    endtask

    task automatic write_vec(input int v);
        @(negedge clk); vec_cfg_we = 1'b1; vec_cfg_data = 8'(v);
        @(negedge clk); vec_cfg_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual=%h expected=%h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [MW-1:0] model;
        repeat (3) @(negedge clk);
        chk_mask("R11 in reset", '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_mask("R11 after reset", '0);

        // R1 R2 R3: sweep every message vector
        for (int v = 0; v < 256; v++) begin
            send_msg(v);
            chk_mask(v == 0 ? "R2 vec zero" : (v < MW ? "R1 in range" : "R3 fold"), exp_bit(v));
            do_accept("R5 accept view", exp_bit(v));
            chk_mask("R5 cleared", '0);
        end

        // R4 accumulation over a fixed pattern
        model = '0;
        for (int k = 0; k < 40; k++) begin
            int v;
            v = (k * 37 + 5) % 70;
            send_msg(v);
            model |= exp_bit(v);
            chk_mask("R4 accumulate", model);
        end
        repeat (5) @(negedge clk);
        chk_mask("R4 held idle", model);
        do_accept("R5 accept full", model);
        chk_mask("R5 empty after", '0);

        // R5 arrival in the accept cycle survives
        send_msg(3);
        @(negedge clk); core_accept = 1'b1; msg_valid = 1'b1; msg_vec = 8'd9;
        chk_mask("R5 presented", exp_bit(3));
        @(negedge clk); core_accept = 1'b0; msg_valid = 1'b0;
        chk_mask("R5 same-cycle kept", exp_bit(9));
        do_accept("R5 drain", exp_bit(9));

        // R8 pin vector resets to 0; R7 timing
        @(negedge clk); ext_nmi_pin = 1'b1;
        @(negedge clk); chk_mask("R7 not after 1", '0);
        @(negedge clk); chk_mask("R7 not after 2", '0);
        @(negedge clk); chk_mask("R8 pin reset vec", exp_bit(0));
        do_accept("R7 drain", exp_bit(0));
        repeat (6) @(negedge clk);
        chk_mask("R7 level no retrigger", '0);
        ext_nmi_pin = 1'b0;
        repeat (4) @(negedge clk);
        chk_mask("R7 falling ignored", '0);

        // R9 programmable pin vector sweep
        for (int pv = 0; pv < 24; pv++) begin
            write_vec(pv);
            @(negedge clk); ext_nmi_pin = 1'b1;
            repeat (3) @(negedge clk);
            chk_mask("R9 pin vector", exp_bit(pv));
            ext_nmi_pin = 1'b0;
            repeat (3) @(negedge clk);
            do_accept("R9 drain", exp_bit(pv));
        end

        // R10 message and pin same cycle
        write_vec(2);
        @(negedge clk); ext_nmi_pin = 1'b1;
        @(negedge clk);
        @(negedge clk); msg_valid = 1'b1; msg_vec = 8'd7;
        @(negedge clk); msg_valid = 1'b0;
        chk_mask("R10 both set", exp_bit(2) | exp_bit(7));
        ext_nmi_pin = 1'b0;
        repeat (3) @(negedge clk);
        do_accept("R10 drain", exp_bit(2) | exp_bit(7));
        chk_mask("R10 clear", '0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule